// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds the stores of an out-of-order core between dispatch and the moment memory accepts them. Stores take a slot in program order, each tagged with a sequence number, and the slot index goes back to the dispatcher. Address, access size and data arrive later through a separate write port. A commit input marks every store whose sequence number is at or below a given value as ready to drain. Ready stores leave one at a time, oldest first, through a writeback port with a ready handshake. A slot is freed only when memory acknowledges that the store is done. A squash input pulls the tail back to drop every store younger than a given sequence number.

Loads ask the queue whether an older store can supply their data. A load gives the queue index it captured at dispatch, its address and its size. The queue walks from the youngest older store toward the writeback pointer and stops at the first store whose bytes overlap the load. There are three outcomes. If the load lies wholly inside that store, the queue forwards the bytes. If the overlap is only partial, it reports a conflict and the load must replay. If nothing overlaps, it reports a miss. The answer appears one cycle after the question.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0, `wb_valid` is 0 and `rsp_valid` is 0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both high. It fills slot `alloc_idx`, and `alloc_idx` then advances by one, modulo ENTRIES. The queue holds at most ENTRIES-1 stores. At that count `alloc_ready` is 0, and an allocation request leaves `alloc_idx` unchanged.
- R3: `rsp_valid` is high exactly in the cycle after the cycle in which `lk_valid` was high.
- R4: Suppose the load range [lk_addr, lk_addr+lk_size) lies inside the range of the selected store. Then `rsp_kind` is 1 (forward). Byte j of `rsp_data`, for j below lk_size, is store byte ((lk_addr AND (store size - 1)) + j), and the higher bytes are zero.
- R5: Suppose the selected store overlaps the load only partially. Then `rsp_kind` is 2 (conflict) and `rsp_data` is zero.
- R6: If no store in the scan window overlaps the load, `rsp_kind` is 0 (miss) and `rsp_data` is zero.
- R7: The scan starts at slot `lk_sq_idx`-1 and moves toward older slots. The first overlapping store decides the result, even when an older store would contain the load fully.
- R8: The scan skips stores whose size is still 0 (no address written yet) and stores marked uncacheable.
- R9: The scan ends at the writeback pointer. Stores already sent to memory are never seen by a lookup.
- R10: A commit sets the drain-ready mark on each held store whose sequence number is at or below `commit_seq`. `wb_valid` is high only when the store at the writeback pointer carries that mark and has not been sent. The offer, with the same address, size and data, stays up while `wb_ready` is low. Stores leave in slot order.
- R11: A slot is freed only by `wb_ack`. Sending a store does not lower the occupancy, so a full queue stays full until an acknowledge.
- R12: A squash removes every held store with a sequence number above `squash_seq` by moving the tail back. A squash wins over an allocation in the same cycle, and that allocation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request a slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IDX_W | Slot the next allocation takes (tail) |
| wr_valid | input | 1 | Fill address, size and data of a slot |
| wr_idx | input | IDX_W | Slot being filled |
| wr_addr | input | ADDR_W | Store byte address |
| wr_size | input | SIZE_W | Store size in bytes (1..DATA_BYTES, power of two) |
| wr_uncache | input | 1 | Store is uncacheable and must not forward |
| wr_data | input | 8*DATA_BYTES | Store data, byte 0 in the low bits |
| commit_valid | input | 1 | Commit stores up to a sequence number |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Drop younger stores |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| lk_valid | input | 1 | Load forwarding lookup |
| lk_sq_idx | input | IDX_W | Queue tail the load captured at dispatch |
| lk_addr | input | ADDR_W | Load byte address |
| lk_size | input | SIZE_W | Load size in bytes |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_kind | output | 2 | 0 miss, 1 forward, 2 conflict |
| rsp_data | output | 8*DATA_BYTES | Forwarded bytes, low aligned |
| wb_valid | output | 1 | A committed store is offered to memory |
| wb_ready | input | 1 | Memory accepts the offered store |
| wb_addr | output | ADDR_W | Address of the offered store |
| wb_size | output | SIZE_W | Size of the offered store |
| wb_data | output | 8*DATA_BYTES | Data of the offered store |
| wb_ack | input | 1 | Memory finished the oldest sent store |

## Verification
A lookup answer is registered, so it is due one edge after the cycle that carries `lk_valid`. The bench drives each lookup on a falling edge and reads the answer on the next falling edge. The writeback offer is combinational from registered state, so it is due right after the edge that stores the commit or moves the writeback pointer. The bench checks `wb_valid` and its fields on the falling edge that follows such an edge. Allocation, squash and acknowledge change `alloc_idx` and `alloc_ready` at the next edge, and each is sampled one falling edge later. The forwarding sweep computes the expected kind and bytes for every load address and size around one store from the containment and overlap arithmetic alone.

// File: rtl/sq_pkg.sv
// Package: shared types of the store queue.
// Assumes: nothing; holds only the lookup result encoding.
package sq_pkg;
    typedef enum logic [1:0] {
        LK_MISS     = 2'd0,
        LK_FWD      = 2'd1,
        LK_CONFLICT = 2'd2
    } lk_kind_e;
endpackage

// File: rtl/sq_overlap.sv
// Module: sq_overlap
// Compares one load byte range with one store byte range.
// Reports containment (load inside store) and any overlap at all.
// Assumes: sizes are byte counts; a store with size 0 or the uncacheable
// mark counts as absent and never matches.
module sq_overlap #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 5
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              st_unc,
    output logic              contain,
    output logic              touch
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic             usable;

    // Range ends with one spare bit so that a sum never wraps.
    always_comb begin
        ld_lo  = {1'b0, ld_addr};
        st_lo  = {1'b0, st_addr};
        ld_hi  = ld_lo + EXT_W'(ld_size);
        st_hi  = st_lo + EXT_W'(st_size);
        usable = (st_size != '0) && !st_unc;
    end

    // Containment and overlap tests for this slot.
    always_comb begin
        contain = usable && (ld_lo >= st_lo) && (ld_hi <= st_hi);
        touch   = usable && (ld_lo < st_hi) && (ld_hi > st_lo);
    end
endmodule

// File: rtl/sq_ptr_ctrl.sv
// Module: sq_ptr_ctrl
// Keeps the three circular pointers of the store queue: head (oldest
// held store), writeback pointer (next store to send) and tail (next free slot).
// Assumes: ENTRIES is a power of two; one slot stays empty as sentinel;
// callers only ack when a sent store exists and only send below tail.
module sq_ptr_ctrl #(
    parameter int ENTRIES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_fire,
    input  logic                         send_fire,
    input  logic                         ack_fire,
    input  logic                         squash_valid,
    input  logic [$clog2(ENTRIES)-1:0]   keep_cnt,
    output logic [$clog2(ENTRIES)-1:0]   head,
    output logic [$clog2(ENTRIES)-1:0]   wb_ptr,
    output logic [$clog2(ENTRIES)-1:0]   tail,
    output logic [$clog2(ENTRIES)-1:0]   count,
    output logic                         full
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] CAP = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] head_q, wb_q, tail_q;

    // Pointer advance; a squash rebuilds the tail from the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            wb_q   <= '0;
            tail_q <= '0;
        end else begin
            if (ack_fire)  head_q <= head_q + IDX_W'(1);
            if (send_fire) wb_q   <= wb_q + IDX_W'(1);
            if (squash_valid)    tail_q <= head_q + keep_cnt;
            else if (alloc_fire) tail_q <= tail_q + IDX_W'(1);
        end
    end

    // Occupancy and full flag from the pointer distance.
    always_comb begin
        head   = head_q;
        wb_ptr = wb_q;
        tail   = tail_q;
        count  = tail_q - head_q;
        full   = (count == CAP);
    end

    // R2: an accepted allocation with no squash or ack grows the count by one.
    a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !squash_valid && !ack_fire) |=> (count == $past(count) + IDX_W'(1)));

    // R11: without an acknowledge the occupancy never drops except by squash.
    a_r11_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_fire && !squash_valid) |=> (count >= $past(count)));

    // R12: a squash never grows the queue.
    a_r12_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !ack_fire) |=> (count <= $past(count)));

    // R9: the writeback pointer stays between head and tail.
    a_r9_wb_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((wb_q - head_q) <= count));
endmodule

// File: rtl/sq_fwd_pick.sv
// Module: sq_fwd_pick
// Walks the scan window from the load's dispatch index toward older slots,
// stops at the writeback pointer, takes the first slot that overlaps the
// load, and registers the kind and the aligned data one cycle later.
// Assumes: per-slot containment and overlap come from sq_overlap; store
// sizes are powers of two so the offset mask picks the right bytes.
module sq_fwd_pick
    import sq_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              lk_valid,
    input  logic [$clog2(ENTRIES)-1:0]        lk_sq_idx,
    input  logic [ADDR_W-1:0]                 lk_addr,
    input  logic [$clog2(DATA_BYTES):0]       lk_size,
    input  logic [$clog2(ENTRIES)-1:0]        wb_ptr,
    input  logic                              hit_full [ENTRIES],
    input  logic                              hit_any  [ENTRIES],
    input  logic [$clog2(DATA_BYTES):0]       st_size  [ENTRIES],
    input  logic [8*DATA_BYTES-1:0]           st_data  [ENTRIES],
    output logic                              rsp_valid,
    output lk_kind_e                          rsp_kind,
    output logic [8*DATA_BYTES-1:0]           rsp_data
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int OFF_W  = $clog2(DATA_BYTES);
    localparam int SIZE_W = OFF_W + 1;
    localparam int DATA_W = 8 * DATA_BYTES;

    logic [IDX_W-1:0]  win_len;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_found;
    lk_kind_e          sel_kind;
    logic [OFF_W-1:0]  sel_off;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] masked;

    // Youngest-first priority scan over the live window.
    always_comb begin
        win_len   = lk_sq_idx - wb_ptr;
        sel_idx   = '0;
        sel_found = 1'b0;
        sel_kind  = LK_MISS;
        for (int d = 0; d < ENTRIES; d++) begin
            logic [IDX_W-1:0] pos;
            pos = lk_sq_idx - IDX_W'(1) - IDX_W'(d);
            if (!sel_found && (IDX_W'(d) < win_len) && hit_any[pos]) begin
                sel_found = 1'b1;
                sel_idx   = pos;
                sel_kind  = hit_full[pos] ? LK_FWD : LK_CONFLICT;
            end
        end
    end

    // Shift the chosen store's bytes by the masked offset and trim to load size.
    always_comb begin
        logic [SIZE_W-1:0] sz_m1;
        sz_m1   = st_size[sel_idx] - SIZE_W'(1);
        sel_off = lk_addr[OFF_W-1:0] & sz_m1[OFF_W-1:0];
        shifted = st_data[sel_idx] >> {sel_off, 3'b000};
        masked  = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (SIZE_W'(b) < lk_size) masked[8*b +: 8] = shifted[8*b +: 8];
        end
    end

    // Result register: one cycle from question to answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= LK_MISS;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_kind  <= sel_kind;
            rsp_data  <= (sel_kind == LK_FWD) ? masked : '0;
        end
    end

    // R3: an answer follows every lookup, one cycle later.
    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R3: no answer appears without a lookup the cycle before.
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R5, R6: only a forward carries data.
    a_r5_no_data_unless_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != LK_FWD) |-> (rsp_data == '0));
endmodule

// File: rtl/store_fwd_queue.sv
// Module: store_fwd_queue (top)
// Circular store queue with in-order drain and load forwarding.
// Holds per-slot sequence, address, size, data, uncacheable,
// drain-ready and sent marks. Per-slot comparators feed a youngest-first
// picker, and pointer control handles allocation, send, release and squash.
// Assumes: ENTRIES is a power of two; sequence numbers grow in program order
// without wrap inside the window; squash never reaches a committed store.
module store_fwd_queue
    import sq_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int SEQ_W      = 8,
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc_valid,
    input  logic [SEQ_W-1:0]                  alloc_seq,
    output logic                              alloc_ready,
    output logic [$clog2(ENTRIES)-1:0]        alloc_idx,
    input  logic                              wr_valid,
    input  logic [$clog2(ENTRIES)-1:0]        wr_idx,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [$clog2(DATA_BYTES):0]       wr_size,
    input  logic                              wr_uncache,
    input  logic [8*DATA_BYTES-1:0]           wr_data,
    input  logic                              commit_valid,
    input  logic [SEQ_W-1:0]                  commit_seq,
    input  logic                              squash_valid,
    input  logic [SEQ_W-1:0]                  squash_seq,
    input  logic                              lk_valid,
    input  logic [$clog2(ENTRIES)-1:0]        lk_sq_idx,
    input  logic [ADDR_W-1:0]                 lk_addr,
    input  logic [$clog2(DATA_BYTES):0]       lk_size,
    output logic                              rsp_valid,
    output logic [1:0]                        rsp_kind,
    output logic [8*DATA_BYTES-1:0]           rsp_data,
    output logic                              wb_valid,
    input  logic                              wb_ready,
    output logic [ADDR_W-1:0]                 wb_addr,
    output logic [$clog2(DATA_BYTES):0]       wb_size,
    output logic [8*DATA_BYTES-1:0]           wb_data,
    input  logic                              wb_ack
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int SIZE_W = $clog2(DATA_BYTES) + 1;
    localparam int DATA_W = 8 * DATA_BYTES;

    // Slot storage.
    logic [SEQ_W-1:0]  seq_q   [ENTRIES];
    logic [ADDR_W-1:0] addr_q  [ENTRIES];
    logic [SIZE_W-1:0] size_q  [ENTRIES];
    logic [DATA_W-1:0] data_q  [ENTRIES];
    logic              unc_q   [ENTRIES];
    logic              ready_q [ENTRIES];
    logic              sent_q  [ENTRIES];

    logic [IDX_W-1:0] head, wb_ptr, tail, count, keep_cnt;
    logic             full, alloc_fire, send_fire, ack_fire;
    logic             held     [ENTRIES];
    logic             hit_full [ENTRIES];
    logic             hit_any  [ENTRIES];
    lk_kind_e         kind_w;

    // Handshake qualifiers at the block edge.
    always_comb begin
        alloc_ready = !full;
        alloc_idx   = tail;
        alloc_fire  = alloc_valid && !full && !squash_valid;
        wb_valid    = (wb_ptr != tail) && ready_q[wb_ptr] && !sent_q[wb_ptr];
        wb_addr     = addr_q[wb_ptr];
        wb_size     = size_q[wb_ptr];
        wb_data     = data_q[wb_ptr];
        send_fire   = wb_valid && wb_ready;
        ack_fire    = wb_ack && (head != wb_ptr);
        rsp_kind    = kind_w;
    end

    // Which slots hold a store, and how many survive a squash.
    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            held[i] = ((IDX_W'(i) - head) < count);
            if (held[i] && (seq_q[i] <= squash_seq)) keep_cnt = keep_cnt + IDX_W'(1);
        end
    end

    // Slot field updates: allocate, fill, commit mark, sent mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                seq_q[i]   <= '0;
                addr_q[i]  <= '0;
                size_q[i]  <= '0;
                data_q[i]  <= '0;
                unc_q[i]   <= 1'b0;
                ready_q[i] <= 1'b0;
                sent_q[i]  <= 1'b0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (alloc_fire && (tail == IDX_W'(i))) begin
                    seq_q[i]   <= alloc_seq;
                    size_q[i]  <= '0;
                    unc_q[i]   <= 1'b0;
                    ready_q[i] <= 1'b0;
                    sent_q[i]  <= 1'b0;
                end
                if (wr_valid && (wr_idx == IDX_W'(i))) begin
                    addr_q[i] <= wr_addr;
                    size_q[i] <= wr_size;
                    unc_q[i]  <= wr_uncache;
                    data_q[i] <= wr_data;
                end
                if (commit_valid && held[i] && (seq_q[i] <= commit_seq)) ready_q[i] <= 1'b1;
                if (send_fire && (wb_ptr == IDX_W'(i))) sent_q[i] <= 1'b1;
            end
        end
    end

    // Pointer control.
    sq_ptr_ctrl #(.ENTRIES(ENTRIES)) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire   (alloc_fire),
        .send_fire    (send_fire),
        .ack_fire     (ack_fire),
        .squash_valid (squash_valid),
        .keep_cnt     (keep_cnt),
        .head         (head),
        .wb_ptr       (wb_ptr),
        .tail         (tail),
        .count        (count),
        .full         (full)
    );

    // One range comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        sq_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cmp (
            .ld_addr (lk_addr),
            .ld_size (lk_size),
            .st_addr (addr_q[g]),
            .st_size (size_q[g]),
            .st_unc  (unc_q[g]),
            .contain (hit_full[g]),
            .touch   (hit_any[g])
        );
    end

    // Youngest-first selection and registered answer.
    sq_fwd_pick #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_sq_idx (lk_sq_idx),
        .lk_addr   (lk_addr),
        .lk_size   (lk_size),
        .wb_ptr    (wb_ptr),
        .hit_full  (hit_full),
        .hit_any   (hit_any),
        .st_size   (size_q),
        .st_data   (data_q),
        .rsp_valid (rsp_valid),
        .rsp_kind  (kind_w),
        .rsp_data  (rsp_data)
    );

    // R10: a stalled offer holds with the same store.
    a_r10_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready && !wb_ack) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

    // R2: a full queue refuses allocation and keeps its tail.
    a_r2_full_keeps_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !squash_valid) |=> $stable(alloc_idx));

    // R11: an acknowledge only arrives for a store already sent.
    a_r11_ack_after_send: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> (head != wb_ptr));
endmodule

// File: tb/store_fwd_queue_bench.sv
module store_fwd_queue_bench;
    localparam int E = 8, SW = 8, AW = 16, DB = 16, IW = 3, ZW = 5, DW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0; logic [SW-1:0] alloc_seq = 0;
    logic alloc_ready; logic [IW-1:0] alloc_idx;
    logic wr_valid = 0; logic [IW-1:0] wr_idx = 0; logic [AW-1:0] wr_addr = 0;
    logic [ZW-1:0] wr_size = 0; logic wr_uncache = 0; logic [DW-1:0] wr_data = 0;
    logic commit_valid = 0; logic [SW-1:0] commit_seq = 0;
    logic squash_valid = 0; logic [SW-1:0] squash_seq = 0;
    logic lk_valid = 0; logic [IW-1:0] lk_sq_idx = 0; logic [AW-1:0] lk_addr = 0;
    logic [ZW-1:0] lk_size = 0;
    logic rsp_valid; logic [1:0] rsp_kind; logic [DW-1:0] rsp_data;
    logic wb_valid; logic wb_ready = 0; logic [AW-1:0] wb_addr;
    logic [ZW-1:0] wb_size; logic [DW-1:0] wb_data; logic wb_ack = 0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    store_fwd_queue #(.ENTRIES(E), .SEQ_W(SW), .ADDR_W(AW), .DATA_BYTES(DB)) u_store_fwd_queue (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_uncache(wr_uncache), .wr_data(wr_data),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .lk_valid(lk_valid), .lk_sq_idx(lk_sq_idx), .lk_addr(lk_addr), .lk_size(lk_size),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_size(wb_size),
        .wb_data(wb_data), .wb_ack(wb_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic alloc(input logic [SW-1:0] s);
        alloc_valid = 1; alloc_seq = s; tick(); alloc_valid = 0;
    endtask

    task automatic fill(input logic [IW-1:0] i, input logic [AW-1:0] a, input logic [ZW-1:0] z,
                        input bit u, input logic [DW-1:0] d);
        wr_valid = 1; wr_idx = i; wr_addr = a; wr_size = z; wr_uncache = u; wr_data = d;
        tick(); wr_valid = 0;
    endtask

    // Drive a lookup; after the next edge the answer is on the outputs.
    task automatic look(input logic [IW-1:0] i, input logic [AW-1:0] a, input logic [ZW-1:0] z);
        lk_valid = 1; lk_sq_idx = i; lk_addr = a; lk_size = z; tick(); lk_valid = 0;
    endtask

    task automatic chk_rsp(input string req, input logic [1:0] k, input logic [DW-1:0] d);
        chk(rsp_valid == 1'b1, req, DW'(rsp_valid), DW'(1));
        chk(rsp_kind == k, req, DW'(rsp_kind), DW'(k));
        chk(rsp_data == d, req, rsp_data, d);
    endtask

    function automatic logic [DW-1:0] bytes_from(input int base, input int first, input int n);
        logic [DW-1:0] r = '0;
        for (int j = 0; j < n; j++) r[8*j +: 8] = 8'(base + first + j);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d0, d2;
        d0 = bytes_from(8'hC0, 0, 8);
        d2 = bytes_from(8'h50, 0, 4);
        repeat (3) tick();
        rst_n = 1; tick();

        // R1: empty after reset.
        chk(alloc_ready == 1, "R1", DW'(alloc_ready), DW'(1));
        chk(alloc_idx == 0, "R1", DW'(alloc_idx), DW'(0));
        chk(wb_valid == 0, "R1", DW'(wb_valid), DW'(0));
        chk(rsp_valid == 0, "R1", DW'(rsp_valid), DW'(0));

        // R2: fill to capacity, index advances each time.
        for (int s = 1; s <= 7; s++) begin
            chk(alloc_idx == IW'(s - 1), "R2", DW'(alloc_idx), DW'(s - 1));
            alloc(SW'(s));
        end
        chk(alloc_ready == 0, "R2", DW'(alloc_ready), DW'(0));
        alloc(8'd8);
        chk(alloc_idx == 3'd7, "R2", DW'(alloc_idx), DW'(7));

        // R12: squash to seq 3 keeps slots 0..2; squash beats a same-cycle allocation.
        squash_valid = 1; squash_seq = 8'd3; alloc_valid = 1; alloc_seq = 8'd9;
        tick(); squash_valid = 0; alloc_valid = 0;
        chk(alloc_idx == 3'd3, "R12", DW'(alloc_idx), DW'(3));
        chk(alloc_ready == 1, "R12", DW'(alloc_ready), DW'(1));

        // Fill slot 0 (addr 16, 8 bytes) and slot 1 (uncacheable); slot 2 left empty.
        fill(3'd0, 16'd16, 5'd8, 1'b0, d0);
        fill(3'd1, 16'd64, 5'd4, 1'b1, bytes_from(8'h70, 0, 4));

        // R8: empty slot 2 and uncacheable slot 1 are skipped.
        look(3'd3, 16'd16, 5'd4);
        chk_rsp("R8", 2'd1, bytes_from(8'hC0, 0, 4));
        look(3'd3, 16'd64, 5'd4);
        chk_rsp("R8", 2'd0, '0);

        // R4 R5 R6: sweep load address and size around the store at 16..23.
        for (int a = 8; a < 32; a++) begin
            for (int zl = 0; zl < 4; zl++) begin
                int z;
                logic [1:0] ek;
                logic [DW-1:0] ed;
                z = 1 << zl;
                if (a >= 16 && a + z <= 24) begin
                    ek = 2'd1; ed = bytes_from(8'hC0, a & 7, z);
                end else if (a < 24 && a + z > 16) begin
                    ek = 2'd2; ed = '0;
                end else begin
                    ek = 2'd0; ed = '0;
                end
                look(3'd1, AW'(a), ZW'(z));
                chk_rsp(ek == 2'd1 ? "R4" : (ek == 2'd2 ? "R5" : "R6"), ek, ed);
            end
        end

        // R7: youngest overlapping store decides.
        fill(3'd2, 16'd20, 5'd4, 1'b0, d2);
        look(3'd3, 16'd20, 5'd4);
        chk_rsp("R7", 2'd1, d2);
        look(3'd3, 16'd22, 5'd2);
        chk_rsp("R7", 2'd1, bytes_from(8'h50, 2, 2));
        look(3'd3, 16'd16, 5'd8);
        chk_rsp("R7", 2'd2, '0);

        // R10: no offer before commit; offer after commit held while not ready.
        chk(wb_valid == 0, "R10", DW'(wb_valid), DW'(0));
        commit_valid = 1; commit_seq = 8'd1; tick(); commit_valid = 0;
        chk(wb_valid == 1, "R10", DW'(wb_valid), DW'(1));
        chk(wb_addr == 16'd16, "R10", DW'(wb_addr), DW'(16));
        tick();
        chk(wb_valid == 1 && wb_data == d0 && wb_size == 5'd8, "R10", wb_data, d0);
        wb_ready = 1; tick(); wb_ready = 0;
        chk(wb_valid == 0, "R10", DW'(wb_valid), DW'(0));

        // R9: the sent store is outside every scan window.
        look(3'd1, 16'd16, 5'd8);
        chk_rsp("R9", 2'd0, '0);
        look(3'd3, 16'd20, 5'd4);
        chk_rsp("R9", 2'd1, d2);

        // R10: next committed store is the next slot in order.
        commit_valid = 1; commit_seq = 8'd2; tick(); commit_valid = 0;
        chk(wb_valid == 1 && wb_addr == 16'd64, "R10", DW'(wb_addr), DW'(64));

        // R11: sending does not free; fill to full, then an ack frees one slot.
        for (int s = 10; s <= 13; s++) alloc(SW'(s));
        chk(alloc_ready == 0, "R11", DW'(alloc_ready), DW'(0));
        wb_ack = 1; tick(); wb_ack = 0;
        chk(alloc_ready == 1, "R11", DW'(alloc_ready), DW'(1));
        chk(alloc_idx == 3'd7, "R11", DW'(alloc_idx), DW'(7));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule